// File: doc/BRIEF.md
# PCI Target Register Port

This block is a 32-bit PCI target that answers single-word I/O and memory transactions aimed at a small bank of eight 32-bit registers. The base of the decode window is fixed by a parameter, and the block has no configuration space. The block watches the shared bus. It captures the address and command on the first clock edge that sees FRAME# low. It decides on the next edge whether the cycle is its own. It then claims the cycle and moves one word in either direction. A read word carries even parity, which the block drives one clock behind the data.

Decode always uses medium timing, so the claim happens on the second edge after FRAME# is first seen. Each transaction moves exactly one data phase. An initiator that still holds FRAME# when the target claims gets STOP# together with TRDY#, and the transfer is cut after that word. Every output has its own output-enable signal, which stands in for a tri-state pad. The control outputs are driven high for one clock after the transaction before they are released.

Top module: `pci_target_port`

## Requirements
- R1: After reset, DEVSEL#, TRDY# and STOP# are high and every output enable is low. All eight registers read back as zero.
- R2: The address and command are captured on the first edge that samples FRAME# low. DEVSEL# goes low after the following edge and not before. It stays low until FRAME# has been sampled high after the data phase.
- R3: TRDY# goes low in the same clock as DEVSEL#. A data phase completes only on an edge that samples both IRDY# and TRDY# low. While IRDY# stays high, TRDY# stays low.
- R4: On a write, AD[4:2] selects the register. Byte n (bits 8n+7:8n) is written only when C/BE#[n] is 0 in the data phase. All other bytes keep their old value.
- R5: On a read, the selected register is driven on ad_o with ad_oe high from the clock TRDY# goes low until the data phase completes. ad_oe is never high outside that interval.
- R6: In the clock after any clock in which ad_oe is high, par_oe is high and par_o equals the XOR of the previous clock's ad_o[31:0] and C/BE#[3:0]. This is even parity.
- R7: If FRAME# is low on the edge where the target claims, STOP# goes low together with TRDY# and stays low until FRAME# is sampled high. Otherwise STOP# stays high. TRDY# goes high on the edge that completes the data phase, so only one word moves per transaction.
- R8: Only commands 0010 (I/O read), 0011 (I/O write), 0110 (memory read) and 0111 (memory write) are claimed, and only when AD[31:5] equals the base address bits [31:5]. For any other cycle, the target drives nothing and no register changes.
- R9: When the transaction ends, DEVSEL#, TRDY# and STOP# are driven high with ctl_oe still high for one clock. ctl_oe then goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| ad_i | input | 32 | Address/data bus as seen at the pads |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables after it |
| ad_o | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Output enable for ad_o |
| par_o | output | 1 | Even parity over the previous clock's AD and C/BE# |
| par_oe | output | 1 | Output enable for par_o |
| devsel_n | output | 1 | DEVSEL# |
| trdy_n | output | 1 | TRDY# |
| stop_n | output | 1 | STOP# |
| ctl_oe | output | 1 | Output enable for DEVSEL#, TRDY# and STOP# |

## Verification
On every cycle, the assertions check the following: the claim lag behind FRAME#, TRDY# held through initiator wait states, the single-word limit, parity one clock behind read data, STOP# only under DEVSEL#, and the release one clock after DEVSEL# rises. The bench scenarios are needed for the rest. These are the byte-masked write contents, the read data, the address and command decode including the ignored cycles, and the choice between STOP# and plain completion. The bench checks these against a reference register image over random and directed transactions.

// File: rtl/ptp_pkg.sv
package ptp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_DATA,
        ST_HOLD,
        ST_TURN,
        ST_SKIP
    } ptp_state_e;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    typedef struct packed {
        ptp_state_e  st;
        logic [29:0] addr;      // word address, AD[31:2]
        logic [3:0]  cmd;
        logic [31:0] ad_o;
        logic        ad_oe;
        logic        trdy_n;
        logic        devsel_n;
        logic        stop_n;
        logic        ctl_oe;
    } ptp_regs_t;

endpackage

// File: rtl/ptp_decode.sv
module ptp_decode
    import ptp_pkg::*;
#(
    parameter int          NUM_WORDS = 8,
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
    localparam int         IDX_W     = $clog2(NUM_WORDS),
    localparam int         WIN_LSB   = IDX_W + 2
) (
    input  logic [29:0]      addr,
    input  logic [3:0]       cmd,
    output logic             hit,
    output logic             is_write,
    output logic [IDX_W-1:0] idx
);

    logic cmd_ok;

    always_comb begin
        cmd_ok   = (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR) ||
                   (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
        hit      = cmd_ok && (addr[29:WIN_LSB-2] == BASE_ADDR[31:WIN_LSB]);
        is_write = cmd[0];
        idx      = addr[IDX_W-1:0];
    end

endmodule

// File: rtl/ptp_regbank.sv
module ptp_regbank #(
    parameter int  NUM_WORDS = 8,
    localparam int IDX_W     = $clog2(NUM_WORDS),
    localparam int NBYTES    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [NBYTES-1:0] wr_be_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_data
);

    logic [31:0] words [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [31:0] word_q;
        logic        sel;

        assign sel = wr_en && (wr_idx == IDX_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (sel) begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (!wr_be_n[b]) word_q[8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end

        assign words[w] = word_q;
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/ptp_parity.sv
module ptp_parity (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ad,
    input  logic [3:0]  cbe_n,
    input  logic        ad_oe,
    output logic        par_o,
    output logic        par_oe
);

    logic par_d, par_q, oe_q;

    always_comb par_d = ^{ad, cbe_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            par_q <= par_d;
            oe_q  <= ad_oe;
        end
    end

    assign par_o  = par_q;
    assign par_oe = oe_q;

endmodule

// File: rtl/pci_target_port.sv
module pci_target_port
    import ptp_pkg::*;
#(
    parameter int          NUM_WORDS = 8,
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
    localparam int         IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic [31:0] ad_i,
    input  logic [3:0]  cbe_n,
    output logic [31:0] ad_o,
    output logic        ad_oe,
    output logic        par_o,
    output logic        par_oe,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic        ctl_oe
);

    ptp_regs_t        q, d;
    logic             hit, is_write, wr_en;
    logic [IDX_W-1:0] idx;
    logic [31:0]      rd_data;

    ptp_decode #(.NUM_WORDS(NUM_WORDS), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr     (q.addr),
        .cmd      (q.cmd),
        .hit      (hit),
        .is_write (is_write),
        .idx      (idx)
    );

    ptp_regbank #(.NUM_WORDS(NUM_WORDS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (ad_i),
        .wr_be_n (cbe_n),
        .rd_idx  (idx),
        .rd_data (rd_data)
    );

    ptp_parity u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .ad     (q.ad_o),
        .cbe_n  (cbe_n),
        .ad_oe  (q.ad_oe),
        .par_o  (par_o),
        .par_oe (par_oe)
    );

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.ctl_oe = 1'b0;
                if (!frame_n) begin
                    d.addr = ad_i[31:2];
                    d.cmd  = cbe_n;
                    d.st   = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (hit) begin
                    d.st       = ST_DATA;
                    d.devsel_n = 1'b0;
                    d.trdy_n   = 1'b0;
                    d.stop_n   = frame_n;   // initiator still wants more: disconnect
                    d.ctl_oe   = 1'b1;
                    if (!is_write) begin
                        d.ad_o  = rd_data;
                        d.ad_oe = 1'b1;
                    end
                end else begin
                    d.st = ST_SKIP;
                end
            end
            ST_DATA: begin
                if (!irdy_n) begin
                    wr_en    = is_write;
                    d.trdy_n = 1'b1;
                    d.ad_oe  = 1'b0;
                    if (frame_n) begin
                        d.st       = ST_TURN;
                        d.devsel_n = 1'b1;
                        d.stop_n   = 1'b1;
                    end else begin
                        d.st = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (frame_n) begin
                    d.st       = ST_TURN;
                    d.devsel_n = 1'b1;
                    d.stop_n   = 1'b1;
                end
            end
            ST_TURN: begin
                d.ctl_oe = 1'b0;
                d.st     = ST_IDLE;
            end
            ST_SKIP: begin
                if (frame_n && irdy_n) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.trdy_n   <= 1'b1;
            q.devsel_n <= 1'b1;
            q.stop_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ad_o     = q.ad_o;
    assign ad_oe    = q.ad_oe;
    assign devsel_n = q.devsel_n;
    assign trdy_n   = q.trdy_n;
    assign stop_n   = q.stop_n;
    assign ctl_oe   = q.ctl_oe;

endmodule

// File: rtl/ptp_checker.sv
module ptp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_n,
    input logic        irdy_n,
    input logic [3:0]  cbe_n,
    input logic [31:0] ad_o,
    input logic        ad_oe,
    input logic        par_o,
    input logic        par_oe,
    input logic        devsel_n,
    input logic        trdy_n,
    input logic        stop_n,
    input logic        ctl_oe
);

    assert_claim_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> !$past(frame_n, 2));

    assert_trdy_claimed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> (!devsel_n && ctl_oe));

    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n) |=> !trdy_n);

    assert_one_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n) |=> trdy_n);

    assert_ad_in_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !trdy_n);

    assert_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> (par_oe && (par_o == ^{$past(ad_o), $past(cbe_n)})));

    assert_stop_claimed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> !devsel_n);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_n) |=> !ctl_oe);

endmodule

bind pci_target_port ptp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .cbe_n    (cbe_n),
    .ad_o     (ad_o),
    .ad_oe    (ad_oe),
    .par_o    (par_o),
    .par_oe   (par_oe),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n),
    .ctl_oe   (ctl_oe)
);

// File: tb/pci_target_port_bench.sv
module pci_target_port_bench;

    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_o;
    logic        ad_oe, par_o, par_oe, devsel_n, trdy_n, stop_n, ctl_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model [8];

    always #5 clk = ~clk;

    pci_target_port #(.NUM_WORDS(8), .BASE_ADDR(BASE)) u_pci_target_port (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad_i(ad_i), .cbe_n(cbe_n), .ad_o(ad_o), .ad_oe(ad_oe),
        .par_o(par_o), .par_oe(par_oe), .devsel_n(devsel_n),
        .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [3:0] cmd, input logic [31:0] addr);
        return (cmd == 4'b0010 || cmd == 4'b0011 || cmd == 4'b0110 || cmd == 4'b0111)
               && (addr[31:5] == BASE[31:5]);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd, input logic [3:0] be_n);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (!be_n[b]) r[8*b +: 8] = wd[8*b +: 8];
        return r;
    endfunction

    task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [3:0] be_n, input bit burst, input int waits);
        bit hit = exp_hit(cmd, addr);
        bit rd = !cmd[0];
        int idx = int'(addr[4:2]);
        bit stop_exp;
        @(negedge clk);
        frame_n = 1'b0; ad_i = addr; cbe_n = cmd; irdy_n = 1'b1;
        @(negedge clk);
        chk(devsel_n === 1'b1, "R2 no claim after first edge", 32'(devsel_n), 32'd1);
        cbe_n = be_n;
        ad_i = rd ? $urandom : wd;
        if (!hit) begin
            frame_n = 1'b1; irdy_n = 1'b0;
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                chk(devsel_n === 1'b1 && ctl_oe === 1'b0 && ad_oe === 1'b0 && trdy_n === 1'b1,
                    "R8 ignored cycle drives nothing", {devsel_n, ctl_oe, ad_oe, trdy_n}, 32'b1001);
                irdy_n = 1'b1;
            end
            return;
        end
        frame_n = (waits == 0 && !burst) ? 1'b1 : 1'b0;
        irdy_n  = (waits == 0) ? 1'b0 : 1'b1;
        stop_exp = (waits > 0) || burst;
        @(negedge clk);
        chk(devsel_n === 1'b0 && trdy_n === 1'b0, "R3 DEVSEL and TRDY low after second edge",
            {devsel_n, trdy_n}, 32'b00);
        chk(stop_n === !stop_exp, "R7 STOP with TRDY when FRAME held", 32'(stop_n), 32'(!stop_exp));
        chk(ad_oe === rd, "R5 AD enable on read only", 32'(ad_oe), 32'(rd));
        if (rd) chk(ad_o === model[idx], "R5 read data", ad_o, model[idx]);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            chk(trdy_n === 1'b0 && devsel_n === 1'b0, "R3 TRDY held during initiator wait",
                {trdy_n, devsel_n}, 32'b00);
        end
        irdy_n = 1'b0;
        frame_n = burst ? 1'b0 : 1'b1;
        @(negedge clk);
        chk(trdy_n === 1'b1 && ad_oe === 1'b0, "R7 single word then TRDY high", {trdy_n, ad_oe}, 32'b10);
        chk(par_oe === rd, "R6 parity enable follows read data", 32'(par_oe), 32'(rd));
        if (rd) chk(par_o === ^{model[idx], be_n}, "R6 even parity", 32'(par_o), 32'(^{model[idx], be_n}));
        if (!rd) model[idx] = merge(model[idx], wd, be_n);
        if (burst) begin
            chk(devsel_n === 1'b0 && stop_n === 1'b0, "R7 STOP and DEVSEL held while FRAME low",
                {devsel_n, stop_n}, 32'b00);
            frame_n = 1'b1;
            @(negedge clk);
        end
        chk(devsel_n === 1'b1 && trdy_n === 1'b1 && stop_n === 1'b1 && ctl_oe === 1'b1,
            "R9 controls driven high for turnaround", {devsel_n, trdy_n, stop_n, ctl_oe}, 32'b1111);
        irdy_n = 1'b1; frame_n = 1'b1;
        @(negedge clk);
        chk(ctl_oe === 1'b0, "R9 controls released", 32'(ctl_oe), 32'd0);
    endtask

    task automatic readback(input int idx);
        xact(4'b0110, BASE | 32'(idx << 2), 32'h0, 4'h0, 1'b0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk(devsel_n === 1'b1 && trdy_n === 1'b1 && stop_n === 1'b1, "R1 reset levels",
            {devsel_n, trdy_n, stop_n}, 32'b111);
        chk(ctl_oe === 1'b0 && ad_oe === 1'b0 && par_oe === 1'b0, "R1 reset enables",
            {ctl_oe, ad_oe, par_oe}, 32'b000);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all registers zero
        for (int i = 0; i < 8; i++) readback(i);
        // R4: full word writes to every register, I/O and memory commands
        for (int i = 0; i < 8; i++)
            xact((i % 2) ? 4'b0011 : 4'b0111, BASE | 32'(i << 2), 32'hA5000000 | 32'(i * 32'h01010101),
                 4'h0, 1'b0, 0);
        for (int i = 0; i < 8; i++) readback(i);
        // R4: partial byte enables
        xact(4'b0111, BASE | 32'h8, 32'h11223344, 4'b1010, 1'b0, 0);
        xact(4'b0011, BASE | 32'h8, 32'hDEADBEEF, 4'b1111, 1'b0, 1);
        readback(2);
        // R7: burst write and burst read are cut after one word
        xact(4'b0111, BASE | 32'h1C, 32'hCAFEF00D, 4'h0, 1'b1, 0);
        xact(4'b0110, BASE | 32'h1C, 32'h0, 4'h0, 1'b1, 2);
        // R3: initiator wait states on a read
        xact(4'b0010, BASE | 32'h4, 32'h0, 4'h0, 1'b0, 3);
        // R8: unsupported command inside the window, write outside the window
        xact(4'b1011, BASE | 32'hC, 32'hFFFFFFFF, 4'h0, 1'b0, 0);
        xact(4'b0111, BASE ^ 32'h0001_0000, 32'hFFFFFFFF, 4'h0, 1'b0, 0);
        xact(4'b0001, BASE | 32'hC, 32'hFFFFFFFF, 4'h0, 1'b0, 0);
        readback(3);
        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [3:0]  cmd;
            logic [31:0] addr;
            int sel = int'($urandom_range(0, 9));
            case (sel)
                0, 1, 2: cmd = 4'b0110;
                3, 4, 5: cmd = 4'b0111;
                6:       cmd = 4'b0010;
                7:       cmd = 4'b0011;
                default: cmd = 4'($urandom);
            endcase
            addr = ($urandom_range(0, 3) != 0) ? (BASE | 32'($urandom_range(0, 31))) : $urandom;
            xact(cmd, addr, $urandom, 4'($urandom), 1'($urandom_range(0, 3) == 0),
                 int'($urandom_range(0, 2)));
        end
        for (int i = 0; i < 8; i++) readback(i);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule